// File: doc/BRIEF.md
# Dual-Node Master/Standby Role Arbiter

Each of two identical redundant computer nodes carries one copy of this block. It decides whether its own node acts as master or as standby. It reports two discrete lines to the partner node: "available" and "master". It watches the partner's copy of those two lines and a local fatal-error indication. Only the master may drive the peripheral outputs, so the block produces an output enable for the peripheral drivers. It also produces a passivation level that forces the node's critical outputs into a safe state once the node has lost availability. Both nodes receive all inputs whatever their role.

Errors are handled asymmetrically. When the master detects a fault, it withdraws both lines, and the healthy standby takes the master role. When the standby detects a fault, it only withdraws its availability, and the roles stay as they were. Only a single fault is tolerated: once both nodes have failed, the pair as a whole is out of service.

The partner lines are asynchronous. Each passes through a two-flop synchronizer and then a per-line persistence filter before any decision uses it.

At power-up, a strap input settles which node becomes master when both nodes are healthy and neither is yet master. Each time a standby becomes master, the block raises a one-cycle pulse so that software can restart its interrupted transactions.

Top module: `role_arbiter`

## Requirements
- R1: While reset is held, and until power-up resolution, the block drives avail_o=1, role_o=0, master_en_o=0, passivate_o=0 and takeover_pulse_o=0.
- R2: Power-up resolution is taken on the rising edge numbered STABLE_CYCLES+4, counting the first edge with reset released as edge 1. The rules apply in this order: if the partner is master, this node becomes standby; otherwise, if the partner is unavailable, this node becomes master; otherwise node_id_i=0 becomes master and node_id_i=1 becomes standby.
- R3: A standby node becomes master when the filtered partner availability is 0, or when the filtered partner master line falls to 0 after having been seen at 1 during standby. role_o rises on the rising edge numbered STABLE_CYCLES+3, counting the first edge that samples the changed line as edge 1.
- R4: A change on a partner line that lasts fewer than STABLE_CYCLES clock cycles is ignored, and the role does not change.
- R5: takeover_pulse_o is 1 for exactly the first cycle of master after a standby-to-master change, and it stays 0 when master is reached at power-up resolution.
- R6: On the first rising edge that samples fatal_err_i=1, the node enters a failed state with avail_o=0, role_o=0, master_en_o=0 and passivate_o=1. The failed state lasts until reset, even after fatal_err_i returns to 0.
- R7: A fault in a standby node never raises role_o, while a fault in the master node drops role_o, which lets the partner take over.
- R8: A failed node never becomes master, whatever the partner lines do.
- R9: master_en_o is 1 exactly when role_o is 1, and passivate_o is the inverse of avail_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id_i | input | 1 | Strap input: 0 wins the master role at power-up when both nodes are healthy |
| fatal_err_i | input | 1 | Local fatal error indication |
| peer_avail_i | input | 1 | Partner availability line (asynchronous) |
| peer_role_i | input | 1 | Partner master line (asynchronous) |
| avail_o | output | 1 | This node's availability line, sent to the partner |
| role_o | output | 1 | This node's master line, sent to the partner (1 = master) |
| master_en_o | output | 1 | Enable for the peripheral output drivers |
| passivate_o | output | 1 | Forces the critical outputs into a passive state |
| takeover_pulse_o | output | 1 | One-cycle pulse on each standby-to-master change |

## Verification
A partner-line change reaches role_o on the rising edge numbered STABLE_CYCLES+3: two synchronizer flops, STABLE_CYCLES filter cycles and the state register. Power-up resolution lands on edge STABLE_CYCLES+4 after reset release, and a local fault shows on the very next edge. Each check drives its inputs at a falling edge and counts rising edges from there. It samples one time unit after the edge just before the expected change and again after the edge of the change, so a result that arrives a cycle early or late is reported. Glitch tests hold a partner line for one cycle less than the filter length, and then for exactly that length, to pin down the filter boundary.

// File: rtl/role_arb_pkg.sv
package role_arb_pkg;
  typedef enum logic [1:0] {
    ST_INIT    = 2'd0,
    ST_STANDBY = 2'd1,
    ST_MASTER  = 2'd2,
    ST_FAILED  = 2'd3
  } role_state_e;
endpackage

// File: rtl/role_arb_sync.sv
module role_arb_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_i[i];
        stable_q <= meta_q;
      end
    end
    assign sync_o[i] = stable_q;
  end
endmodule

// File: rtl/role_arb_filter.sv
module role_arb_filter #(
  parameter int WIDTH         = 2,
  parameter int STABLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] filt_o
);
  localparam int CNT_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_CYCLES - 1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [CNT_W-1:0] run_q;
    logic             val_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= '0;
        val_q <= 1'b0;
      end else if (raw_i[i] == val_q) begin
        run_q <= '0;
      end else if (run_q == LIMIT) begin
        val_q <= raw_i[i];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
    assign filt_o[i] = val_q;
  end
endmodule

// File: rtl/role_arb_fsm.sv
module role_arb_fsm
  import role_arb_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        node_id_i,
  input  logic        fatal_err_i,
  input  logic        peer_avail_f,
  input  logic        peer_role_f,
  output role_state_e state_o,
  output logic        takeover_o
);
  localparam int SETTLE = STABLE_CYCLES + 4;
  localparam int SW     = $clog2(SETTLE + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE - 1);

  role_state_e state_q, state_d;
  logic [SW-1:0] settle_q;
  logic          seen_q;
  logic          pulse_q;
  logic          go_master;

  always_comb begin
    state_d   = state_q;
    go_master = 1'b0;
    case (state_q)
      ST_INIT: begin
        if (settle_q == SETTLE_LAST) begin
          if (peer_role_f)       state_d = ST_STANDBY;
          else if (!peer_avail_f) state_d = ST_MASTER;
          else                    state_d = node_id_i ? ST_STANDBY : ST_MASTER;
        end
      end
      ST_STANDBY: begin
        if (!peer_avail_f || (seen_q && !peer_role_f)) begin
          state_d   = ST_MASTER;
          go_master = 1'b1;
        end
      end
      default: state_d = state_q;
    endcase
    if (fatal_err_i) begin
      state_d   = ST_FAILED;
      go_master = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_INIT;
      settle_q <= '0;
      seen_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= go_master;
      if (state_q == ST_INIT && settle_q != SETTLE_LAST)
        settle_q <= settle_q + 1'b1;
      if (state_q == ST_STANDBY && peer_role_f)
        seen_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign takeover_o = pulse_q;
endmodule

// File: rtl/role_arbiter.sv
module role_arbiter
  import role_arb_pkg::*;
#(
  parameter int STABLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic node_id_i,
  input  logic fatal_err_i,
  input  logic peer_avail_i,
  input  logic peer_role_i,
  output logic avail_o,
  output logic role_o,
  output logic master_en_o,
  output logic passivate_o,
  output logic takeover_pulse_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] peer_sync, peer_filt;
  role_state_e      state;
  logic             pulse;

  role_arb_sync #(.WIDTH(LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({peer_avail_i, peer_role_i}),
    .sync_o  (peer_sync)
  );

  role_arb_filter #(.WIDTH(LINES), .STABLE_CYCLES(STABLE_CYCLES)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (peer_sync),
    .filt_o (peer_filt)
  );

  role_arb_fsm #(.STABLE_CYCLES(STABLE_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .node_id_i    (node_id_i),
    .fatal_err_i  (fatal_err_i),
    .peer_avail_f (peer_filt[1]),
    .peer_role_f  (peer_filt[0]),
    .state_o      (state),
    .takeover_o   (pulse)
  );

  assign avail_o          = (state != ST_FAILED);
  assign role_o           = (state == ST_MASTER);
  assign master_en_o      = role_o;
  assign passivate_o      = !avail_o;
  assign takeover_pulse_o = pulse;
endmodule

// File: rtl/role_arbiter_chk.sv
module role_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic fatal_err_i,
  input logic avail_o,
  input logic role_o,
  input logic master_en_o,
  input logic passivate_o,
  input logic takeover_pulse_o
);
  // R6: a fault is visible on the next edge
  p_err_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err_i |=> (!avail_o && passivate_o && !role_o));

  // R6: failure is sticky
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_o |=> !avail_o);

  // R8: failed node is never master
  p_fail_no_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !avail_o |-> (!role_o && !master_en_o));

  // R7: standby fault raises no role
  p_standby_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!role_o && fatal_err_i) |=> !role_o);

  // R5: pulse lasts one cycle and marks the first master cycle
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    takeover_pulse_o |=> !takeover_pulse_o);

  p_pulse_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    takeover_pulse_o |-> (role_o && !$past(role_o)));

  // R9: enable only while available and not passive
  p_en_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    master_en_o |-> (avail_o && !passivate_o));
endmodule

bind role_arbiter role_arbiter_chk u_chk (.*);

// File: tb/role_arbiter_tb.sv
`timescale 1ns/1ps
module role_arbiter_tb;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic node_id = 1'b0, fatal = 1'b0, p_avail = 1'b0, p_role = 1'b0;
  logic avail, role, men, pas, pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  role_arbiter #(.STABLE_CYCLES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .node_id_i(node_id), .fatal_err_i(fatal),
    .peer_avail_i(p_avail), .peer_role_i(p_role),
    .avail_o(avail), .role_o(role), .master_en_o(men),
    .passivate_o(pas), .takeover_pulse_o(pulse)
  );

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual avail/role/en/pas/pulse=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] outs();
    return {avail, role, men, pas, pulse};
  endfunction

  // reset, then resolution; returns after the decision edge
  task automatic start(input logic id, input logic pa, input logic pr, input logic [4:0] exp);
    rst_n = 1'b0; fatal = 1'b0; node_id = id; p_avail = pa; p_role = pr;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", outs(), 5'b10000);
    @(negedge clk) rst_n = 1'b1;
    repeat (S + 3) @(posedge clk);
    #1 chk("R1 before resolution", outs(), 5'b10000);
    @(posedge clk);
    #1 chk("R2 resolution", outs(), exp);
  endtask

  task automatic t_resolve();
    start(1'b0, 1'b1, 1'b0, 5'b11100);  // R2 id0 wins, R5 no pulse
    start(1'b1, 1'b1, 1'b0, 5'b10000);  // R2 id1 standby
    repeat (30) @(posedge clk);
    #1 chk("R3 no takeover without seen master", outs(), 5'b10000);
    start(1'b0, 1'b1, 1'b1, 5'b10000);  // R2 partner already master
    start(1'b1, 1'b0, 1'b0, 5'b11100);  // R2 partner unavailable
  endtask

  task automatic t_takeover_role();
    start(1'b1, 1'b1, 1'b1, 5'b10000);
    repeat (3) @(posedge clk);
    @(negedge clk) p_role = 1'b0;
    repeat (S + 2) @(posedge clk);
    #1 chk("R3 role not yet", outs(), 5'b10000);
    @(posedge clk);
    #1 chk("R3 R5 takeover with pulse", outs(), 5'b11101);
    @(posedge clk);
    #1 chk("R5 pulse one cycle", outs(), 5'b11100);
  endtask

  task automatic t_takeover_avail();
    start(1'b0, 1'b1, 1'b1, 5'b10000);
    repeat (3) @(posedge clk);
    @(negedge clk) p_avail = 1'b0;
    repeat (S + 2) @(posedge clk);
    #1 chk("R3 avail loss not yet", outs(), 5'b10000);
    @(posedge clk);
    #1 chk("R3 avail loss takeover", outs(), 5'b11101);
  endtask

  task automatic t_glitch();
    start(1'b1, 1'b1, 1'b1, 5'b10000);
    repeat (3) @(posedge clk);
    @(negedge clk) p_role = 1'b0;
    repeat (S - 1) @(negedge clk);
    p_role = 1'b1;
    repeat (20) @(posedge clk);
    #1 chk("R4 short glitch ignored", outs(), 5'b10000);
    @(negedge clk) p_role = 1'b0;
    repeat (S) @(negedge clk);
    p_role = 1'b1;
    repeat (20) @(posedge clk);
    #1 chk("R4 full-length change accepted", outs(), 5'b11100);
  endtask

  task automatic t_standby_fault();
    start(1'b1, 1'b1, 1'b1, 5'b10000);
    repeat (3) @(posedge clk);
    @(negedge clk) fatal = 1'b1;
    @(posedge clk);
    #1 chk("R6 R7 standby fault", outs(), 5'b00010);
    @(negedge clk) fatal = 1'b0; p_role = 1'b0; p_avail = 1'b0;
    repeat (30) @(posedge clk);
    #1 chk("R8 failed node no takeover", outs(), 5'b00010);
  endtask

  task automatic t_master_fault();
    start(1'b0, 1'b1, 1'b0, 5'b11100);
    repeat (3) @(posedge clk);
    @(negedge clk) fatal = 1'b1;
    @(posedge clk);
    #1 chk("R7 master fault drops role", outs(), 5'b00010);
    @(negedge clk) fatal = 1'b0;
    repeat (10) @(posedge clk);
    #1 chk("R6 failure sticky", outs(), 5'b00010);
    chk("R9 enable tracks role", {3'b000, men, role}, {3'b000, role, 1'b0});
  endtask

  initial begin
    t_resolve();
    t_takeover_role();
    t_takeover_avail();
    t_glitch();
    t_standby_fault();
    t_master_fault();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule